// File: doc/BRIEF.md
# Configuration ROM Request Mapper

This block sits between a serial-bus link and host memory. It looks at each incoming read request that names the node's configuration ROM window. The window is 1 KB, from bus offset 0xFFFF_F000_0400 up to 0xFFFF_F000_07FF.

The first five quadlets of the window are answered on the spot from local inputs. Quadlet 0 is the ROM header. Quadlets 1 to 4 form the bus information block, and the 64-bit unique identifier fills quadlets 3 and 4. Every other aligned quadlet read in the window becomes a single host memory read. Its address is a programmable, 1 KB-aligned base plus the low ten offset bits. When the host data returns, the block hands it back as the response.

Anything else is refused with a type-error acknowledgement. That covers other transaction types, misaligned offsets, offsets outside the window, and mapped reads made while software has not yet declared the base valid.

Only one request is in flight at a time. The request side is ready only while the block is idle.

Top module: `cfgrom_mapper`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. It is a type error (`rsp_ack` = 1) when any of these holds: its transaction code is not 4 (quadlet read), or offset bits 47:10 differ from those of 0xFFFF_F000_0400.
- R2: A request whose offset bits 1:0 are non-zero is answered with a type error (`rsp_ack` = 1) and issues no host read.
- R3: Quadlet index `offset[9:2]` values 0 to 4 are answered with `rsp_ack` = 0 (complete) and issue no host read. The data returned for each index is:
  - index 0: `rom_header`
  - index 1: `bus_info_w1`
  - index 2: `bus_info_w2`
  - index 3: `node_uid[63:32]`
  - index 4: `node_uid[31:0]`
- R4: A write with `cfg_wr_en` high and `cfg_addr` = 0x34 loads bits 31:10 of `cfg_wdata` into the base register. Bits 9:0 of `map_base` always read zero, whatever was written. Writes to other addresses leave the base unchanged.
- R5: For an accepted aligned quadlet read with index 5 to 255 while `map_ready` is high, `hrd_addr` equals `map_base` plus `offset[9:0]`.
- R6: While `map_ready` is low, a request that would be mapped gets a type error and issues no host read. Indices 0 to 4 are still answered locally.
- R7: At most one host read is outstanding. `hrd_valid` and `hrd_addr` stay unchanged until `hrd_ready` is seen. `req_ready` is low from acceptance until the response cycle has passed.
- R8: `rsp_valid` is a single-cycle pulse.
  - For a local or rejected request, it comes in the cycle after acceptance.
  - For a mapped read, it comes in the cycle after `hdata_valid`, with `rsp_data` equal to `hdata` and `rsp_ack` = 0.
- R9: After reset, `req_ready` = 1, `hrd_valid` = 0, `rsp_valid` = 0 and `map_base` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can take a request |
| req_tcode | input | 4 | Transaction code (4 = quadlet read) |
| req_offset | input | 48 | Bus offset of the request |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| map_base | output | 32 | Current base register value |
| map_ready | input | 1 | Base is valid; mapped reads allowed |
| rom_header | input | 32 | ROM header quadlet |
| bus_info_w1 | input | 32 | Bus info quadlet 1 |
| bus_info_w2 | input | 32 | Bus info quadlet 2 |
| node_uid | input | 64 | Unique identifier |
| hrd_valid | output | 1 | Host read request |
| hrd_ready | input | 1 | Host accepts read |
| hrd_addr | output | 32 | Host byte address |
| hdata_valid | input | 1 | Host read data returned |
| hdata | input | 32 | Host read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_ack | output | 2 | 0 = complete, 1 = type error |
| rsp_data | output | 32 | Response quadlet |

## Verification
The mapped path is driven with several patterns:
- the first mapped index (5) and the last (255), with two different base values, which separates concatenation slips from off-by-one errors in the index;
- each local index 0 to 4 with distinct word values, which shows whether the identifier halves or the bus-info words are swapped;
- host handshakes with different ready and data delays, which exposes responses that do not wait for `hdata_valid`.

The reject paths are probed one cause at a time, so that each condition is shown to act on its own:
- wrong transaction code;
- misalignment;
- offsets just above and just below the window;
- `map_ready` low.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam int ROFF_W = 10;
  localparam int HADDR_W = 32;
  localparam logic [3:0] TC_QREAD = 4'h4;

  typedef enum logic [1:0] {
    ACK_COMPLETE = 2'd0,
    ACK_TYPE_ERR = 2'd1
  } ack_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HREQ,
    ST_HWAIT,
    ST_RESP
  } st_e;

  typedef struct packed {
    logic              reject;
    logic              local_hit;
    logic [31:0]       local_data;
    logic [ROFF_W-1:0] rom_off;
  } dec_t;
endpackage

// File: rtl/cfgrom_decode.sv
module cfgrom_decode
  import cfgrom_pkg::*;
#(
  parameter int          OFF_W    = 48,
  parameter logic [47:0] WIN_BASE = 48'hFFFF_F000_0400,
  parameter int          LOCAL_Q  = 5
) (
  input  logic [3:0]       tcode,
  input  logic [OFF_W-1:0] offset,
  input  logic [31:0]      rom_header,
  input  logic [31:0]      bus_info_w1,
  input  logic [31:0]      bus_info_w2,
  input  logic [63:0]      node_uid,
  output dec_t             dec
);
  localparam int IDX_W = ROFF_W - 2;

  logic             in_win;
  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic [31:0]      lq [LOCAL_Q];

  assign lq[0] = rom_header;
  assign lq[1] = bus_info_w1;
  assign lq[2] = bus_info_w2;
  assign lq[3] = node_uid[63:32];
  assign lq[4] = node_uid[31:0];

  assign in_win  = (offset[OFF_W-1:ROFF_W] == WIN_BASE[OFF_W-1:ROFF_W]);
  assign aligned = (offset[1:0] == 2'b00);
  assign idx     = offset[ROFF_W-1:2];

  always_comb begin
    dec.reject     = !in_win || (tcode != TC_QREAD) || !aligned;
    dec.local_hit  = (idx < IDX_W'(LOCAL_Q));
    dec.rom_off    = offset[ROFF_W-1:0];
    dec.local_data = '0;
    for (int i = 0; i < LOCAL_Q; i++) begin
      if (idx == IDX_W'(i)) dec.local_data = lq[i];
    end
  end
endmodule

// File: rtl/cfgrom_base_reg.sv
module cfgrom_base_reg
  import cfgrom_pkg::*;
#(
  parameter int               AW      = 8,
  parameter logic [AW-1:0]    REG_OFF = 8'h34
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [31:0]        wdata,
  output logic [HADDR_W-1:0] base
);
  logic                      hit;
  logic [HADDR_W-1:ROFF_W]   base_q, base_d;

  assign hit = wr_en && (addr == REG_OFF);

  always_comb begin
    base_d = base_q;
    if (hit) base_d = wdata[HADDR_W-1:ROFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (hit) base_q <= base_d;
  end

  assign base = {base_q, {ROFF_W{1'b0}}};

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (base[HADDR_W-1:ROFF_W] == $past(wdata[HADDR_W-1:ROFF_W]))); // R4
endmodule

// File: rtl/cfgrom_ctrl.sv
module cfgrom_ctrl
  import cfgrom_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  dec_t               dec,
  input  logic               map_ready,
  input  logic [HADDR_W-1:0] base,
  output logic               req_ready,
  output logic               hrd_valid,
  input  logic               hrd_ready,
  output logic [HADDR_W-1:0] hrd_addr,
  input  logic               hdata_valid,
  input  logic [31:0]        hdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_ack,
  output logic [31:0]        rsp_data
);
  st_e                st_q, st_d;
  logic [HADDR_W-1:0] addr_q, addr_d;
  ack_e               ack_q, ack_d;
  logic [31:0]        data_q, data_d;
  logic               accept;

  assign accept = req_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    ack_d  = ack_q;
    data_d = data_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        data_d = '0;
        ack_d  = ACK_TYPE_ERR;
        st_d   = ST_RESP;
        if (!dec.reject && dec.local_hit) begin
          ack_d  = ACK_COMPLETE;
          data_d = dec.local_data;
        end else if (!dec.reject && map_ready) begin
          addr_d = base + HADDR_W'(dec.rom_off);
          st_d   = ST_HREQ;
        end
      end
      ST_HREQ:  if (hrd_ready) st_d = ST_HWAIT;
      ST_HWAIT: if (hdata_valid) begin
        data_d = hdata;
        ack_d  = ACK_COMPLETE;
        st_d   = ST_RESP;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      ack_q  <= ACK_COMPLETE;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      ack_q  <= ack_d;
      data_q <= data_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign hrd_valid = (st_q == ST_HREQ);
  assign hrd_addr  = addr_q;
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_ack   = ack_q;
  assign rsp_data  = data_q;

  AST_HREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hrd_valid && !hrd_ready) |=> (hrd_valid && $stable(hrd_addr))); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrd_valid) |-> $past(map_ready)); // R6
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (hdata_valid && (st_q == ST_HWAIT)) |=> (rsp_valid && rsp_data == $past(hdata))); // R8
endmodule

// File: rtl/cfgrom_mapper.sv
module cfgrom_mapper
  import cfgrom_pkg::*;
#(
  parameter int          OFF_W    = 48,
  parameter logic [47:0] WIN_BASE = 48'hFFFF_F000_0400,
  parameter int          CFG_AW   = 8,
  parameter logic [7:0]  BASE_OFF = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_tcode,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       map_base,
  input  logic              map_ready,
  input  logic [31:0]       rom_header,
  input  logic [31:0]       bus_info_w1,
  input  logic [31:0]       bus_info_w2,
  input  logic [63:0]       node_uid,
  output logic              hrd_valid,
  input  logic              hrd_ready,
  output logic [31:0]       hrd_addr,
  input  logic              hdata_valid,
  input  logic [31:0]       hdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_ack,
  output logic [31:0]       rsp_data
);
  dec_t dec;

  cfgrom_decode #(.OFF_W(OFF_W), .WIN_BASE(WIN_BASE), .LOCAL_Q(5)) u_dec (
    .tcode(req_tcode), .offset(req_offset), .rom_header(rom_header),
    .bus_info_w1(bus_info_w1), .bus_info_w2(bus_info_w2),
    .node_uid(node_uid), .dec(dec)
  );

  cfgrom_base_reg #(.AW(CFG_AW), .REG_OFF(BASE_OFF)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .base(map_base)
  );

  cfgrom_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dec(dec),
    .map_ready(map_ready), .base(map_base), .req_ready(req_ready),
    .hrd_valid(hrd_valid), .hrd_ready(hrd_ready), .hrd_addr(hrd_addr),
    .hdata_valid(hdata_valid), .hdata(hdata), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data)
  );

  AST_HADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hrd_valid |-> (((hrd_addr - map_base) >= 32'd20) && ((hrd_addr - map_base) < 32'd1024))); // R5
  AST_HADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    hrd_valid |-> (hrd_addr[1:0] == 2'b00)); // R2
endmodule

// File: tb/cfgrom_mapper_test.sv
module cfgrom_mapper_test;
  logic        clk = 0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [3:0]  req_tcode;
  logic [47:0] req_offset;
  logic        cfg_wr_en;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata, map_base;
  logic        map_ready;
  logic [31:0] rom_header, bus_info_w1, bus_info_w2;
  logic [63:0] node_uid;
  logic        hrd_valid, hrd_ready;
  logic [31:0] hrd_addr;
  logic        hdata_valid;
  logic [31:0] hdata;
  logic        rsp_valid;
  logic [1:0]  rsp_ack;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int hlat = 1;

  logic [1:0]  exp_ack[$];
  logic [31:0] exp_data[$];
  string       exp_tag[$];
  logic [31:0] exp_haddr[$];

  always #5 clk = ~clk;

  cfgrom_mapper uut (.*);

  function automatic logic [31:0] hmem(input logic [31:0] a);
    return a ^ 32'hC3A5_0000;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: decides the outcome of each request from the requirements.
  task automatic send(input string tag, input logic [3:0] tc, input logic [47:0] off);
    logic        inwin, host;
    logic [7:0]  idx;
    logic [31:0] d;
    logic [1:0]  a;
    while (!req_ready) @(negedge clk);
    inwin = (off >= 48'hFFFF_F000_0400) && (off <= 48'hFFFF_F000_07FF);
    idx   = off[9:2];
    host  = 0;
    d     = 0;
    a     = 2'd1;
    if (inwin && tc == 4'h4 && off[1:0] == 0) begin
      if (idx < 5) begin
        a = 2'd0;
        case (idx)
          0: d = rom_header;
          1: d = bus_info_w1;
          2: d = bus_info_w2;
          3: d = node_uid[63:32];
          default: d = node_uid[31:0];
        endcase
      end else if (map_ready) begin
        host = 1;
        a    = 2'd0;
        d    = hmem(map_base + {22'd0, off[9:0]});
        exp_haddr.push_back(map_base + {22'd0, off[9:0]});
      end
    end
    exp_ack.push_back(a);
    exp_data.push_back(d);
    exp_tag.push_back(tag);
    req_valid  = 1;
    req_tcode  = tc;
    req_offset = off;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " req_ready low while busy"}, req_ready, 0);
    if (!host) chk({tag, " rsp one cycle after accept"}, rsp_valid, 1);
    while (exp_ack.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_wr_en = 1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  // Per-clock comparison of responses and host requests against the model.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_ack.size() == 0) chk("R8 unexpected response", 1, 0);
      else begin
        chk({exp_tag[0], " ack"}, rsp_ack, exp_ack[0]);
        chk({exp_tag[0], " data"}, rsp_data, exp_data[0]);
        void'(exp_ack.pop_front());
        void'(exp_data.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  // Host memory responder with programmable delays.
  initial begin
    hrd_ready = 0;
    hdata_valid = 0;
    hdata = 0;
    forever begin
      @(negedge clk);
      if (rst_n && hrd_valid) begin
        logic [31:0] a;
        a = hrd_addr;
        if (exp_haddr.size() == 0) chk("R6 R3 unexpected host read", 1, 0);
        else begin
          chk("R5 host address", a, exp_haddr[0]);
          void'(exp_haddr.pop_front());
        end
        repeat (hlat) begin
          @(negedge clk);
          chk("R7 hrd held", {hrd_valid, hrd_addr}, {1'b1, a});
        end
        hrd_ready = 1;
        @(negedge clk);
        hrd_ready = 0;
        repeat (hlat) begin
          @(negedge clk);
          chk("R8 no early response", rsp_valid, 0);
        end
        hdata_valid = 1;
        hdata = hmem(a);
        @(negedge clk);
        hdata_valid = 0;
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    req_valid = 0;
    req_tcode = 0;
    req_offset = 0;
    cfg_wr_en = 0;
    cfg_addr = 0;
    cfg_wdata = 0;
    map_ready = 0;
    rom_header  = 32'h0404_1111;
    bus_info_w1 = 32'h3133_3934;
    bus_info_w2 = 32'h2222_F0C3;
    node_uid    = 64'h0800_4601_ABCD_0177;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 req_ready", req_ready, 1);
    chk("R9 hrd_valid", hrd_valid, 0);
    chk("R9 rsp_valid", rsp_valid, 0);
    chk("R9 map_base", map_base, 0);

    // R6: not ready -> mapped refused, local still served
    send("R6 mapped while not ready", 4'h4, 48'hFFFF_F000_0414);
    send("R6 local while not ready", 4'h4, 48'hFFFF_F000_0400);

    // R4: reserved bits ignored, other addresses ignored
    wr(8'h34, 32'h1234_57FF);
    chk("R4 base reserved bits", map_base, 32'h1234_5400);
    wr(8'h30, 32'hFFFF_FFFF);
    chk("R4 other address", map_base, 32'h1234_5400);
    map_ready = 1;

    // R3 local quadlets
    send("R3 header", 4'h4, 48'hFFFF_F000_0400);
    send("R3 info1", 4'h4, 48'hFFFF_F000_0404);
    send("R3 info2", 4'h4, 48'hFFFF_F000_0408);
    send("R3 uid hi", 4'h4, 48'hFFFF_F000_040C);
    send("R3 uid lo", 4'h4, 48'hFFFF_F000_0410);

    // R5 / R8 mapped reads
    send("R5 first mapped", 4'h4, 48'hFFFF_F000_0414);
    hlat = 3;
    send("R5 last mapped", 4'h4, 48'hFFFF_F000_07FC);
    wr(8'h34, 32'h8000_0C00);
    chk("R4 second base", map_base, 32'h8000_0C00);
    hlat = 0;
    send("R8 mapped mid", 4'h4, 48'hFFFF_F000_0600);

    // R1 / R2 rejects
    send("R1 block read tcode", 4'h5, 48'hFFFF_F000_0414);
    send("R1 write tcode", 4'h0, 48'hFFFF_F000_0400);
    send("R1 above window", 4'h4, 48'hFFFF_F000_0800);
    send("R1 below window", 4'h4, 48'hFFFF_F000_03FC);
    send("R2 misaligned mapped", 4'h4, 48'hFFFF_F000_0416);
    send("R2 misaligned local", 4'h4, 48'hFFFF_F000_0401);

    // R7 back-to-back mapped with delays
    hlat = 2;
    send("R7 mapped again", 4'h4, 48'hFFFF_F000_0500);
    chk("R7 host queue drained", exp_haddr.size(), 0);
    chk("R9 idle after run", req_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule